// File: doc/BRIEF.md
# Dual-Port Mailbox RAM with Collision Arbitration

This block is a clocked 1024-word by 8-bit memory with two ports, left and right. Each port has its own enable, write select, 10-bit address and 8-bit data. Either port can read or write any word on any cycle, independently of the other. Read data is registered and appears one cycle after the read is issued.

The two highest words double as mailboxes. A left-port write to 0x3FF raises the right port's interrupt. A right-port write to 0x3FE raises the left port's interrupt. When the receiving port reads or writes its own mailbox word, its interrupt clears. The stored byte at each mailbox word stays ordinary data. With the parameter `MBOX_EN` set to 0, both interrupts are held low and the two words act as plain memory.

When both enabled ports present the same address on the same cycle, the left port wins. The right port's write, if any, is dropped. The right port sees `rt_busy` high on the following cycle, aligned with its read data.

Each interrupt flag is a two-state machine. `FLG_IDLE` moves to `FLG_RAISED` on a set. `FLG_RAISED` returns to `FLG_IDLE` on a clear with no set in the same cycle, and otherwise holds. The arbiter is a two-state machine as well. It enters `ARB_RT_LOST` on any collision cycle and returns to `ARB_FREE` on any cycle without one. `rt_busy` is high exactly in `ARB_RT_LOST`.

Top module: `dpmb_ram`

## Requirements
- R1: A word written by a port is returned on that port's read data one clock after a later read of that address is issued; a read is a cycle with enable 1 and write select 0.
- R2: Accesses by the two ports to different addresses on the same cycle both take effect. A word written by one port is readable by the other.
- R3: With enable 0, a port writes nothing, whatever its write select, and its read data holds its previous value.
- R4: A write cycle does not change that port's read data.
- R5: A left write to 0x3FF sets `rt_irq` high from the next cycle. It stays high until cleared.
- R6: A right-port read or write of 0x3FF clears `rt_irq` on the next cycle.
- R7: A right write to 0x3FE that is not suppressed sets `lt_irq`. A left-port read or write of 0x3FE clears it.
- R8: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: Mailbox words hold user data: a byte written to 0x3FF or 0x3FE reads back unchanged on either port. A read of 0x3FF by the left port leaves `rt_irq` as it was.
- R10: When both ports are enabled with equal addresses, `rt_busy` is high on the next cycle only. `lt_busy` stays 0, and a right read in that cycle returns the word as it was before any left write of that cycle.
- R11: On a collision where both ports write, the left data is stored and the right data is discarded.
- R12: A right write to 0x3FE that is suppressed by a collision leaves `lt_irq` unset.
- R13: Reset forces `lt_irq`, `rt_irq`, `lt_busy` and `rt_busy` to 0. Memory contents are left as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset for flags and arbiter |
| lt_en | input | 1 | Left port enable |
| lt_wr | input | 1 | Left write select (1 = write) |
| lt_addr | input | 10 | Left word address |
| lt_wdata | input | 8 | Left write data |
| lt_rdata | output | 8 | Left registered read data |
| lt_irq | output | 1 | Left mailbox interrupt (set via 0x3FE) |
| lt_busy | output | 1 | Left busy; never raised, since left wins |
| rt_en | input | 1 | Right port enable |
| rt_wr | input | 1 | Right write select (1 = write) |
| rt_addr | input | 10 | Right word address |
| rt_wdata | input | 8 | Right write data |
| rt_rdata | output | 8 | Right registered read data |
| rt_irq | output | 1 | Right mailbox interrupt (set via 0x3FF) |
| rt_busy | output | 1 | High the cycle after the right port lost a collision |

## Verification
A mailbox set or clear can land on the same cycle as a same-address collision, because the set and the clear of one flag both need the two ports at that flag's word. The bench forces this in two ways:
- The left port writes 0x3FF while the right port reads it. The expected result is `rt_irq` high and `rt_busy` high on the next cycle.
- The right port writes 0x3FE while the left port reads it. The expected result is `lt_irq` still low and the old byte left in place.

A randomized phase aims many right addresses at the left address, so these overlaps recur. Every result is compared against a behavioural model.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
    typedef enum logic {
        FLG_IDLE   = 1'b0,
        FLG_RAISED = 1'b1
    } flag_state_t;

    typedef enum logic {
        ARB_FREE    = 1'b0,
        ARB_RT_LOST = 1'b1
    } arb_state_t;
endpackage

// File: rtl/dpmb_flag.sv
module dpmb_flag
    import dpmb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    flag_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_IDLE:   if (set_i) st_d = FLG_RAISED;
            FLG_RAISED: if (clr_i && !set_i) st_d = FLG_IDLE;
            default:    st_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        irq_o = (st_q == FLG_RAISED);
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o);
    // R6
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !irq_o);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(irq_o));
endmodule

// File: rtl/dpmb_arb.sv
module dpmb_arb
    import dpmb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lt_en,
    input  logic [AW-1:0] lt_addr,
    input  logic          rt_en,
    input  logic          rt_wr,
    input  logic [AW-1:0] rt_addr,
    output logic          rt_wr_ok,
    output logic          lt_busy_o,
    output logic          rt_busy_o
);
    arb_state_t st_q, st_d;
    logic       collide;

    assign collide  = lt_en && rt_en && (lt_addr == rt_addr);
    assign rt_wr_ok = rt_en && rt_wr && !collide;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_FREE:    if (collide)  st_d = ARB_RT_LOST;
            ARB_RT_LOST: if (!collide) st_d = ARB_FREE;
            default:     st_d = ARB_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ARB_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        rt_busy_o = (st_q == ARB_RT_LOST);
        lt_busy_o = 1'b0;
    end

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_en && rt_en && lt_addr == rt_addr) |=> rt_busy_o);
    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lt_en && rt_en && lt_addr == rt_addr) |=> !rt_busy_o);
endmodule

// File: rtl/dpmb_store.sv
module dpmb_store #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lt_en,
    input  logic          lt_wr,
    input  logic [AW-1:0] lt_addr,
    input  logic [DW-1:0] lt_wdata,
    input  logic          rt_wr_ok,
    input  logic          rt_rd,
    input  logic [AW-1:0] rt_addr,
    input  logic [DW-1:0] rt_wdata,
    output logic [DW-1:0] lt_q,
    output logic [DW-1:0] rt_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (lt_en && lt_wr) mem[lt_addr] <= lt_wdata;
        if (rt_wr_ok)       mem[rt_addr] <= rt_wdata;
        if (lt_en && !lt_wr) lt_q <= mem[lt_addr];
        if (rt_rd)          rt_q <= mem[rt_addr];
    end

    // R11
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_en && lt_wr && rt_wr_ok) |-> (lt_addr != rt_addr));
endmodule

// File: rtl/dpmb_ram.sv
module dpmb_ram #(
    parameter int AW      = 10,
    parameter int DW      = 8,
    parameter bit MBOX_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lt_en,
    input  logic          lt_wr,
    input  logic [AW-1:0] lt_addr,
    input  logic [DW-1:0] lt_wdata,
    output logic [DW-1:0] lt_rdata,
    output logic          lt_irq,
    output logic          lt_busy,
    input  logic          rt_en,
    input  logic          rt_wr,
    input  logic [AW-1:0] rt_addr,
    input  logic [DW-1:0] rt_wdata,
    output logic [DW-1:0] rt_rdata,
    output logic          rt_irq,
    output logic          rt_busy
);
    localparam logic [AW-1:0] MB_RT = {AW{1'b1}};
    localparam logic [AW-1:0] MB_LT = MB_RT - 1'b1;

    logic rt_wr_ok;

    dpmb_arb #(.AW(AW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lt_en     (lt_en),
        .lt_addr   (lt_addr),
        .rt_en     (rt_en),
        .rt_wr     (rt_wr),
        .rt_addr   (rt_addr),
        .rt_wr_ok  (rt_wr_ok),
        .lt_busy_o (lt_busy),
        .rt_busy_o (rt_busy)
    );

    dpmb_store #(.AW(AW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lt_en    (lt_en),
        .lt_wr    (lt_wr),
        .lt_addr  (lt_addr),
        .lt_wdata (lt_wdata),
        .rt_wr_ok (rt_wr_ok),
        .rt_rd    (rt_en && !rt_wr),
        .rt_addr  (rt_addr),
        .rt_wdata (rt_wdata),
        .lt_q     (lt_rdata),
        .rt_q     (rt_rdata)
    );

    generate
        if (MBOX_EN) begin : g_mbox
            logic lt_set, lt_clr, rt_set, rt_clr;
            assign lt_set = rt_wr_ok && (rt_addr == MB_LT);
            assign lt_clr = lt_en && (lt_addr == MB_LT);
            assign rt_set = lt_en && lt_wr && (lt_addr == MB_RT);
            assign rt_clr = rt_en && (rt_addr == MB_RT);

            dpmb_flag u_lt_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (lt_set),
                .clr_i (lt_clr),
                .irq_o (lt_irq)
            );

            dpmb_flag u_rt_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (rt_set),
                .clr_i (rt_clr),
                .irq_o (rt_irq)
            );

            // R12
            no_lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!lt_irq && lt_en && rt_en && lt_addr == MB_LT && rt_addr == MB_LT)
                |=> !lt_irq);
        end else begin : g_plain
            assign lt_irq = 1'b0;
            assign rt_irq = 1'b0;
        end
    endgenerate
endmodule

// File: tb/tb_dpmb_ram.sv
`timescale 1ns/1ps
module tb_dpmb_ram;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lt_en = 0, lt_wr = 0, rt_en = 0, rt_wr = 0;
    logic [9:0] lt_addr = 0, rt_addr = 0;
    logic [7:0] lt_wdata = 0, rt_wdata = 0;
    logic [7:0] lt_rdata, rt_rdata;
    logic       lt_irq, lt_busy, rt_irq, rt_busy;

    always #2.5 clk = ~clk;

    dpmb_ram dut (
        .clk(clk), .rst_n(rst_n),
        .lt_en(lt_en), .lt_wr(lt_wr), .lt_addr(lt_addr), .lt_wdata(lt_wdata),
        .lt_rdata(lt_rdata), .lt_irq(lt_irq), .lt_busy(lt_busy),
        .rt_en(rt_en), .rt_wr(rt_wr), .rt_addr(rt_addr), .rt_wdata(rt_wdata),
        .rt_rdata(rt_rdata), .rt_irq(rt_irq), .rt_busy(rt_busy)
    );

    typedef struct {
        string      tag;
        logic [7:0] l, r;
        bit         lk, rk;
        bit         li, ri, rb;
    } exp_t;

    exp_t       q[$];
    int         nvec = 0;
    int         nbad = 0;
    logic [7:0] mdl [1024];
    logic [7:0] exp_l, exp_r;
    bit         l_known = 0, r_known = 0;
    bit         f_l = 0, f_r = 0;
    bit         done = 0;

    task automatic fail(string tag, string what, logic [7:0] act, logic [7:0] exp);
        nbad++;
        $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    endtask

    task automatic step(string tag, bit le, bit lw, logic [9:0] la, logic [7:0] ld,
                        bit re, bit rw, logic [9:0] ra, logic [7:0] rd);
        exp_t e;
        bit coll, s_l, c_l, s_r, c_r;
        @(negedge clk);
        lt_en = le; lt_wr = lw; lt_addr = la; lt_wdata = ld;
        rt_en = re; rt_wr = rw; rt_addr = ra; rt_wdata = rd;
        coll = le && re && (la == ra);
        if (le && !lw) begin exp_l = mdl[la]; l_known = 1; end
        if (re && !rw) begin exp_r = mdl[ra]; r_known = 1; end
        s_r = le && lw && (la == 10'h3FF);
        c_r = re && (ra == 10'h3FF);
        s_l = re && rw && !coll && (ra == 10'h3FE);
        c_l = le && (la == 10'h3FE);
        if (le && lw) mdl[la] = ld;
        if (re && rw && !coll) mdl[ra] = rd;
        f_r = s_r ? 1'b1 : (c_r ? 1'b0 : f_r);
        f_l = s_l ? 1'b1 : (c_l ? 1'b0 : f_l);
        e.tag = tag; e.l = exp_l; e.r = exp_r; e.lk = l_known; e.rk = r_known;
        e.li = f_l; e.ri = f_r; e.rb = coll;
        q.push_back(e);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 10'h000, 8'h00, 0, 0, 10'h000, 8'h00);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                nvec++;
                if (e.lk && lt_rdata !== e.l) fail(e.tag, "lt_rdata", lt_rdata, e.l);
                if (e.rk && rt_rdata !== e.r) fail(e.tag, "rt_rdata", rt_rdata, e.r);
                if (lt_irq !== e.li) fail(e.tag, "lt_irq", {7'd0, lt_irq}, {7'd0, e.li});
                if (rt_irq !== e.ri) fail(e.tag, "rt_irq", {7'd0, rt_irq}, {7'd0, e.ri});
                if (rt_busy !== e.rb) fail(e.tag, "rt_busy", {7'd0, rt_busy}, {7'd0, e.rb});
                if (lt_busy !== 1'b0) fail(e.tag, "lt_busy", {7'd0, lt_busy}, 8'h00);
            end
        end
    end

    task automatic reset_check();
        @(negedge clk);
        lt_en = 0; rt_en = 0; rst_n = 0;
        f_l = 0; f_r = 0;
        repeat (2) @(negedge clk);
        nvec++;
        if (lt_irq !== 1'b0) fail("R13", "lt_irq", {7'd0, lt_irq}, 8'h00);
        if (rt_irq !== 1'b0) fail("R13", "rt_irq", {7'd0, rt_irq}, 8'h00);
        if (lt_busy !== 1'b0) fail("R13", "lt_busy", {7'd0, lt_busy}, 8'h00);
        if (rt_busy !== 1'b0) fail("R13", "rt_busy", {7'd0, rt_busy}, 8'h00);
        rst_n = 1;
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            nbad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin : driver
        reset_check();
        // R1 write then read on one port
        step("R1", 1, 1, 10'h010, 8'hA5, 0, 0, 10'h000, 8'h00);
        step("R1", 1, 0, 10'h010, 8'h00, 0, 0, 10'h000, 8'h00);
        idle("R1");
        // R2 concurrent distinct writes, cross reads
        step("R2", 1, 1, 10'h011, 8'h5A, 1, 1, 10'h020, 8'h3C);
        step("R2", 1, 0, 10'h020, 8'h00, 1, 0, 10'h011, 8'h00);
        // R3 disabled port with write select high
        step("R3", 0, 1, 10'h010, 8'hFF, 0, 1, 10'h011, 8'hEE);
        step("R3", 1, 0, 10'h010, 8'h00, 1, 0, 10'h011, 8'h00);
        // R4 write cycle holds read data
        step("R4", 1, 1, 10'h012, 8'h99, 1, 1, 10'h013, 8'h88);
        step("R4", 1, 0, 10'h013, 8'h00, 1, 0, 10'h012, 8'h00);
        // R5 left writes right mailbox
        step("R5", 1, 1, 10'h3FF, 8'h77, 0, 0, 10'h000, 8'h00);
        idle("R5");
        idle("R5");
        // R9 left reads 0x3FF: data back, flag untouched
        step("R9", 1, 0, 10'h3FF, 8'h00, 0, 0, 10'h000, 8'h00);
        // R6 right read clears
        step("R6", 0, 0, 10'h000, 8'h00, 1, 0, 10'h3FF, 8'h00);
        idle("R6");
        // R6 right write clears
        step("R6", 1, 1, 10'h3FF, 8'h66, 0, 0, 10'h000, 8'h00);
        step("R6", 0, 0, 10'h000, 8'h00, 1, 1, 10'h3FF, 8'h55);
        step("R9", 0, 0, 10'h000, 8'h00, 1, 0, 10'h3FF, 8'h00);
        // R7 right writes left mailbox, left read clears
        step("R7", 0, 0, 10'h000, 8'h00, 1, 1, 10'h3FE, 8'h12);
        idle("R7");
        step("R7", 1, 0, 10'h3FE, 8'h00, 0, 0, 10'h000, 8'h00);
        idle("R7");
        // R8 set and clear of rt flag in one cycle (also a collision)
        step("R8", 1, 1, 10'h3FF, 8'h44, 1, 0, 10'h3FF, 8'h00);
        idle("R8");
        step("R6", 0, 0, 10'h000, 8'h00, 1, 0, 10'h3FF, 8'h00);
        // R10 same-address reads
        step("R10", 1, 0, 10'h010, 8'h00, 1, 0, 10'h010, 8'h00);
        idle("R10");
        // R10 right read while left writes same word: old value
        step("R10", 1, 1, 10'h011, 8'hC3, 1, 0, 10'h011, 8'h00);
        step("R10", 0, 0, 10'h000, 8'h00, 1, 0, 10'h011, 8'h00);
        // R11 both write same word
        step("R11", 1, 1, 10'h030, 8'h11, 1, 1, 10'h030, 8'h22);
        step("R11", 1, 0, 10'h030, 8'h00, 1, 0, 10'h030, 8'h00);
        // R12 suppressed right write to 0x3FE
        step("R12", 1, 0, 10'h3FE, 8'h00, 1, 1, 10'h3FE, 8'h99);
        idle("R12");
        step("R12", 1, 0, 10'h3FE, 8'h00, 0, 0, 10'h000, 8'h00);
        // fill low words, then randomized traffic
        for (int i = 0; i < 64; i++)
            step("R2", 1, 1, 10'(i), 8'(i * 37 + 5), 0, 0, 10'h000, 8'h00);
        for (int i = 0; i < 300; i++) begin
            logic [9:0] la, ra;
            bit         le, lw, re, rw;
            le = 1'($urandom); lw = 1'($urandom);
            re = 1'($urandom); rw = 1'($urandom);
            la = ($urandom % 8 == 0) ? (10'h3FE + 10'($urandom % 2)) : 10'($urandom % 64);
            ra = ($urandom % 3 == 0) ? la :
                 (($urandom % 8 == 0) ? (10'h3FE + 10'($urandom % 2)) : 10'($urandom % 64));
            step((le && re && la == ra) ? "R10" : "R2",
                 le, lw, la, 8'($urandom), re, rw, ra, 8'($urandom));
        end
        // R13 reset with a flag raised and busy pending
        step("R13", 1, 1, 10'h3FF, 8'h01, 1, 0, 10'h3FF, 8'h00);
        reset_check();
        step("R13", 1, 0, 10'h3FF, 8'h00, 0, 0, 10'h000, 8'h00);
        idle("R13");
        idle("R13");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule